// File: doc/BRIEF.md
# Low-Power Autoreload Event Timer

A small event timer for a low-power domain. Software programs a reload limit, a power-of-two prescaler and an interrupt mask through a word-addressed register port. It then starts the counter either once or free-running. The counter advances on a prescaled slow-clock tick and flags a match each time it reaches the reload limit. The slow counter clock is modelled by `tick_i`, which is a one-cycle enable in the bus clock domain.

Writes that cross into the slow domain do not land at once. The enable bit makes the timer active only after two ticks. A write to the reload limit or to the interrupt mask lands two ticks after the bus accepts it, and a per-register done flag then reports that the write has landed. The reload limit can only be written while the enable bit is set. A start request made before the timer is active is held until it becomes active.

Register word addresses: 0 control (bit0 enable, bit1 single start, bit2 continuous start), 1 interrupt mask, 2 status (bit0 match, bit1 reload-written, bit2 mask-written, bit3 active), 3 flag clear (write 1 to clear, same bit positions as status bits 0 to 2), 4 configuration (prescaler in bits 11:9), 5 reload limit (16 bits), 6 counter value (read only).

Top module: `lp_event_timer`

## Requirements
- R1: After reset the status reads 0, `irq_o` is 0, the counter reads 0 and the reload limit reads 0xFFFF.
- R2: After control bit0 is written as 1, status bit3 stays 0 after the first later tick and reads 1 after the second later tick.
- R3: A reload write made while control bit0 is 0 is dropped: the readback keeps its old value and status bit1 stays 0.
- R4: A reload write made while enabled reads back the old value after one later tick, and after the second later tick it reads back the new value with status bit1 set.
- R5: An interrupt-mask write lands two ticks after it is accepted: the readback then shows the new value and status bit2 is set.
- R6: With prescaler p (configuration bits 11:9) and reload value a, the first match after a start comes exactly (a+1)·2^p ticks after the start.
- R7: A continuous start (control bit2) matches again every (a+1)·2^p ticks. A single start (control bit1) stops after its first match and leaves the counter at 0.
- R8: A match sets status bit0. `irq_o` is the OR over status bits 0..2 of each bit ANDed with the same bit of the landed mask, and it stays high until the flag is cleared.
- R9: Writing 1 to a bit of the flag-clear register clears only that status flag.
- R10: Writing 0 to the control register makes the timer inactive at once, clears the counter and stops all further matches.
- R11: A start written together with the enable bit while the timer is inactive waits until the timer is active. No tick before that point advances the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow counter-clock tick, one cycle wide |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the window in which a write has been accepted but has not yet landed. This applies to the delayed enable, to a reload write that is one tick into its two-tick crossing, and to a start request held because the timer is still inactive. The bench drives `tick_i` one pulse at a time and reads back between pulses, so it sees the old value, the done flag still clear and a counter that has not moved before the landing tick. It then sees all three change right after that tick. A table of prescaler and reload pairs brings the match to the exact tick count, with a check one tick before the match and one at the match.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_ICLR = 3'd3,
    A_CFG  = 3'd4,
    A_ARR  = 3'd5,
    A_CNT  = 3'd6
  } reg_addr_e;

  localparam int PSC_LSB   = 9;
  localparam int FLAG_W    = 3;
  localparam int F_MATCH   = 0;
  localparam int F_ARRDONE = 1;
  localparam int F_IENDONE = 2;
  localparam int ST_ACTIVE = 3;
  localparam int C_EN      = 0;
  localparam int C_SINGLE  = 1;
  localparam int C_CONT    = 2;
endpackage

// File: rtl/lpt_land.sv
// Holds a written value until DELAY slow ticks after acceptance, then lands it.
module lpt_land #(
  parameter int          W     = 16,
  parameter int          DELAY = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         fire_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  buf_q;
  logic [W-1:0]  data_q;
  logic          fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      buf_q  <= '0;
      data_q <= RST;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (clr_i) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (wr_i) begin
        pend_q <= 1'b1;
        cnt_q  <= '0;
        buf_q  <= data_i;
      end else if (pend_q && tick_i) begin
        if (cnt_q == CW'(DELAY - 1)) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
          data_q <= buf_q;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/lpt_counter.sv
// Prescaled up-counter with reload match, single or continuous.
module lpt_counter #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             start_i,
  input  logic             single_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  localparam int DW = (1 << PSC_W) - 1;

  logic             run_q;
  logic             single_q;
  logic             match_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    div_q;
  logic [DW-1:0]    div_lim;

  assign div_lim = ~({DW{1'b1}} << psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      single_q <= 1'b0;
      match_q  <= 1'b0;
      cnt_q    <= '0;
      div_q    <= '0;
    end else begin
      match_q <= 1'b0;
      if (!active_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        div_q <= '0;
      end else if (start_i) begin
        run_q    <= 1'b1;
        single_q <= single_i;
        cnt_q    <= '0;
        div_q    <= '0;
      end else if (run_q && tick_i) begin
        if (div_q == div_lim) begin
          div_q <= '0;
          if (cnt_q == arr_i) begin
            match_q <= 1'b1;
            cnt_q   <= '0;
            if (single_q) run_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
endmodule

// File: rtl/lp_event_timer.sv
module lp_event_timer #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 3,
  parameter int EN_DLY  = 2,
  parameter int WR_DLY  = 2,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import lpt_pkg::*;

  localparam int EW = $clog2(EN_DLY + 1);

  logic wr_ctrl, wr_ien, wr_iclr, wr_cfg, wr_arr;
  logic wr_en;

  assign wr_en   = req_i & we_i;
  assign wr_ctrl = wr_en && (addr_i == A_CTRL);
  assign wr_ien  = wr_en && (addr_i == A_IEN);
  assign wr_iclr = wr_en && (addr_i == A_ICLR);
  assign wr_cfg  = wr_en && (addr_i == A_CFG);
  assign wr_arr  = wr_en && (addr_i == A_ARR);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  // enable with delayed activation
  logic          en_q, active_q;
  logic [EW-1:0] en_dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      en_dly_q <= '0;
    end else if (wr_ctrl && !wdata_i[C_EN]) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      en_dly_q <= '0;
    end else if (wr_ctrl && !en_q) begin
      en_q     <= 1'b1;
      en_dly_q <= '0;
    end else if (en_q && !active_q && tick_i) begin
      if (en_dly_q == EW'(EN_DLY - 1)) active_q <= 1'b1;
      else en_dly_q <= en_dly_q + 1'b1;
    end
  end

  // start request held until active
  logic start_pend_q, start_single_q, start_go;
  assign start_go = active_q & start_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_pend_q   <= 1'b0;
      start_single_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (wdata_i[C_EN] && (wdata_i[C_SINGLE] || wdata_i[C_CONT])) begin
        start_pend_q   <= 1'b1;
        start_single_q <= ~wdata_i[C_CONT];
      end else begin
        start_pend_q <= 1'b0;
      end
    end else if (start_go) begin
      start_pend_q <= 1'b0;
    end
  end

  logic [PSC_W-1:0] psc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (wr_cfg) psc_q <= wdata_i[PSC_LSB +: PSC_W];
  end

  // write crossings
  logic [CNT_W-1:0]  arr_q;
  logic              arr_fire;
  logic [FLAG_W-1:0] ien_q;
  logic              ien_fire;

  lpt_land #(.W(CNT_W), .DELAY(WR_DLY), .RST(ARR_RST)) u_arr_land (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (~en_q),
    .wr_i   (wr_arr & en_q),
    .data_i (wdata_i[CNT_W-1:0]),
    .data_o (arr_q),
    .fire_o (arr_fire)
  );

  lpt_land #(.W(FLAG_W), .DELAY(WR_DLY), .RST('0)) u_ien_land (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (1'b0),
    .wr_i   (wr_ien),
    .data_i (wdata_i[FLAG_W-1:0]),
    .data_o (ien_q),
    .fire_o (ien_fire)
  );

  logic [CNT_W-1:0] cnt_val;
  logic             cnt_match;

  lpt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .active_i (active_q),
    .start_i  (start_go),
    .single_i (start_single_q),
    .psc_i    (psc_q),
    .arr_i    (arr_q),
    .cnt_o    (cnt_val),
    .match_o  (cnt_match)
  );

  // status flags: set wins over clear in the same cycle
  logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;
  always_comb begin
    flag_set            = '0;
    flag_set[F_MATCH]   = cnt_match;
    flag_set[F_ARRDONE] = arr_fire;
    flag_set[F_IENDONE] = ien_fire;
    flag_clr            = wr_iclr ? wdata_i[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq_o = |(flags_q & ien_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[C_EN] = en_q;
      A_IEN:  rdata_o[FLAG_W-1:0] = ien_q;
      A_STAT: begin
        rdata_o[FLAG_W-1:0] = flags_q;
        rdata_o[ST_ACTIVE]  = active_q;
      end
      A_CFG:  rdata_o[PSC_LSB +: PSC_W] = psc_q;
      A_ARR:  rdata_o[CNT_W-1:0] = arr_q;
      A_CNT:  rdata_o[CNT_W-1:0] = cnt_val;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lp_event_timer_chk.sv
module lp_event_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              en_q,
  input logic              active_q,
  input logic [CNT_W-1:0]  arr_q,
  input logic              cnt_match,
  input logic [FLAG_W-1:0] flags_q,
  input logic              irq_o,
  input logic              wr_iclr,
  input logic              ien_fire
);
  assert_active_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(tick_i));

  assert_arr_frozen_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(arr_q));

  assert_match_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_match |=> flags_q[0]);

  assert_irq_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_iclr && !ien_fire |=> irq_o);

  assert_no_match_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !cnt_match);
endmodule

bind lp_event_timer lp_event_timer_chk #(.CNT_W(CNT_W), .FLAG_W(lpt_pkg::FLAG_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_q      (en_q),
  .active_q  (active_q),
  .arr_q     (arr_q),
  .cnt_match (cnt_match),
  .flags_q   (flags_q),
  .irq_o     (irq_o),
  .wr_iclr   (wr_iclr),
  .ien_fire  (ien_fire)
);

// File: tb/lp_event_timer_tb_top.sv
module lp_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lp_event_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [2:0] CTRL = 0, IEN = 1, STAT = 2, ICLR = 3, CFG = 4, ARR = 5, CNT = 6;

  // {prescaler, reload}
  localparam logic [18:0] VEC [6] = '{
    {3'd0, 16'd1}, {3'd0, 16'd5}, {3'd1, 16'd3},
    {3'd2, 16'd2}, {3'd3, 16'd1}, {3'd7, 16'd1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(STAT, v); chk(v, 0, "R1 status");
    chk({31'd0, irq}, 0, "R1 irq");
    rd(ARR, v);  chk(v, 32'hFFFF, "R1 reload");
    rd(CNT, v);  chk(v, 0, "R1 counter");

    // R3 reload write while disabled is dropped
    wr(ARR, 5); ticks(4);
    rd(ARR, v);  chk(v, 32'hFFFF, "R3 reload kept");
    rd(STAT, v); chk(v, 0, "R3 no done flag");

    // R2 enable delay
    wr(CTRL, 1); ticks(1);
    rd(STAT, v); chk(v, 0, "R2 inactive after 1 tick");
    ticks(1);
    rd(STAT, v); chk(v, 8, "R2 active after 2 ticks");

    // R4 reload crossing
    wr(ARR, 3); ticks(1);
    rd(ARR, v);  chk(v, 32'hFFFF, "R4 old value mid-crossing");
    rd(STAT, v); chk(v, 8, "R4 done flag not yet");
    ticks(1);
    rd(ARR, v);  chk(v, 3, "R4 landed");
    rd(STAT, v); chk(v, 8 | 2, "R4 done flag");
    wr(ICLR, 2);
    rd(STAT, v); chk(v, 8, "R9 clear reload flag");

    // R5 mask crossing
    wr(IEN, 1); ticks(1);
    rd(IEN, v); chk(v, 0, "R5 mask not landed");
    ticks(1);
    rd(IEN, v);  chk(v, 1, "R5 mask landed");
    rd(STAT, v); chk(v, 8 | 4, "R5 done flag");
    chk({31'd0, irq}, 0, "R8 masked flag no irq");
    wr(ICLR, 4);

    // R6 table: exact match tick count
    for (int k = 0; k < 6; k++) begin
      int p, a, n;
      p = int'(VEC[k][18:16]);
      a = int'(VEC[k][15:0]);
      n = (a + 1) << p;
      wr(CTRL, 0);
      wr(CFG, p << 9);
      wr(CTRL, 1); ticks(2);
      wr(ARR, a); ticks(2);
      wr(ICLR, 7);
      wr(CTRL, 1 | 4);
      @(negedge clk); @(negedge clk);
      ticks(n - 1);
      rd(STAT, v); chk(v & 1, 0, $sformatf("R6 no match before tick %0d p=%0d", n, p));
      ticks(1);
      rd(STAT, v); chk(v & 1, 1, $sformatf("R6 match at tick %0d p=%0d", n, p));
      chk({31'd0, irq}, 1, "R8 irq on match");
    end

    // R7 continuous rematch, R8 held irq
    wr(CTRL, 0); wr(CFG, 0);
    wr(CTRL, 1); ticks(2);
    wr(ARR, 2); ticks(2);
    wr(ICLR, 7);
    wr(CTRL, 1 | 4); @(negedge clk); @(negedge clk);
    ticks(3);
    rd(STAT, v); chk(v & 1, 1, "R7 first continuous match");
    repeat (5) @(negedge clk);
    chk({31'd0, irq}, 1, "R8 irq held");
    wr(ICLR, 1);
    chk({31'd0, irq}, 0, "R8 irq drops on clear");
    ticks(2);
    rd(STAT, v); chk(v & 1, 0, "R7 no early rematch");
    ticks(1);
    rd(STAT, v); chk(v & 1, 1, "R7 rematch after period");

    // R10 disable stops at once
    ticks(1);
    wr(CTRL, 0);
    rd(STAT, v); chk(v & 8, 0, "R10 inactive");
    rd(CNT, v);  chk(v, 0, "R10 counter cleared");
    wr(ICLR, 1); ticks(10);
    rd(STAT, v); chk(v & 1, 0, "R10 no match when off");

    // R11 deferred start, reload still 2
    wr(CTRL, 1 | 4); ticks(1);
    rd(CNT, v); chk(v, 0, "R11 counter idle before active");
    ticks(1);
    rd(CNT, v); chk(v, 0, "R11 counter starts at 0");
    ticks(1);
    rd(CNT, v); chk(v, 1, "R11 counts once active");

    // R7 single shot, R9 individual clear
    wr(CTRL, 0);
    wr(CTRL, 1); ticks(2);
    wr(ARR, 2); ticks(2);
    wr(ICLR, 1 | 4);
    wr(CTRL, 1 | 2); @(negedge clk); @(negedge clk);
    ticks(3);
    rd(STAT, v); chk(v & 3, 3, "R9 match and reload flags set");
    wr(ICLR, 1);
    rd(STAT, v); chk(v & 3, 2, "R9 only match cleared");
    ticks(6);
    rd(STAT, v); chk(v & 1, 0, "R7 single no rematch");
    rd(CNT, v);  chk(v, 0, "R7 single counter at 0");

    // R8 masked match
    wr(IEN, 0); ticks(2);
    wr(ICLR, 7);
    wr(CTRL, 1 | 2); @(negedge clk); @(negedge clk);
    ticks(3);
    rd(STAT, v); chk(v & 1, 1, "R8 flag set while masked");
    chk({31'd0, irq}, 0, "R8 masked no irq");

    finish_run();
  end
endmodule